// File: doc/BRIEF.md
# Receive Destination Address Screen

This block decides whether a received Ethernet frame is kept, from its 48-bit destination address alone. Each address is presented with a one-cycle strobe, and the block returns a registered keep/drop verdict on the next cycle. Three short-circuit enables (broadcast accept, group promiscuous, individual promiscuous) can accept a frame at once. When none of them applies, the address is compared in parallel against a bank of exact-match entries. If no entry matches, a 12-bit hash taken from the two last address bytes picks one bit of a 4096-bit table, and that bit decides.

Software-side state is loaded through a simple write port: a control word, the low and high words of each exact-match entry, and the 32-bit words of the hash table. A write lands on a clock edge and affects only strobes taken at later edges. The address is carried with byte 0 (the first byte on the wire) in `addr_i[7:0]` and byte 5 in `addr_i[47:40]`, so the group bit is `addr_i[0]`.

Top module: `rx_dest_screen`

## Requirements
- R1: A strobe on `addr_valid_i` sampled at a clock edge gives `verdict_valid_o` high for exactly the cycle after that edge, carrying that address's verdict; in any cycle without a verdict, `accept_o`, `match_hit_o` and `match_idx_o` are all zero.
- R2: After synchronous reset the control word is zero, every entry is invalid and every hash bit is clear, so every address is rejected.
- R3: An address of all ones is accepted with `match_hit_o` low when control bit 0 (broadcast accept) is set.
- R4: An address with `addr_i[0]` set that is not all ones is accepted with `match_hit_o` low when control bit 1 (group promiscuous) is set; that bit does not accept an all-ones address.
- R5: An address with `addr_i[0]` clear is accepted with `match_hit_o` low when control bit 2 (individual promiscuous) is set.
- R6: When no enable accepted it, an address of any kind, all ones included, equal to `{high[15:0], low[31:0]}` of an entry whose high-word bit 31 is set is accepted with `match_hit_o` high and `match_idx_o` giving the lowest such entry; high-word bits 30:16 are ignored.
- R7: An entry whose high-word bit 31 is clear never matches, and an entry write whose index is not below the entry count changes no entry.
- R8: When neither the enables nor the bank accepted it, the address is accepted exactly when hash-table bit `h[4:0]` of word `h[11:5]` is set, where `h` is `{addr_i[47:40], addr_i[39:32]}` shifted right by 4, 3, 2 or 0 for control bits 5:4 equal to 0, 1, 2 or 3, masked to 12 bits.
- R9: A write taken at the same edge as a strobe does not affect that strobe's verdict.
- R10: The write port selects with `cfg_sel_i`: 0 control word, 1 entry low word, 2 entry high word, 3 hash-table word, indexed by `cfg_idx_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| addr_valid_i | input | 1 | Destination address strobe |
| addr_i | input | 48 | Destination address, byte 0 in bits 7:0 |
| cfg_we_i | input | 1 | Configuration write enable |
| cfg_sel_i | input | 2 | Write target: control, entry low, entry high, hash word |
| cfg_idx_i | input | 7 | Entry index or hash-word index |
| cfg_wdata_i | input | 32 | Write data |
| verdict_valid_o | output | 1 | Verdict present this cycle |
| accept_o | output | 1 | Keep the frame |
| match_hit_o | output | 1 | Verdict came from the exact-match bank |
| match_idx_o | output | 4 | Lowest matching entry index |

## Verification
The bench builds the block with its default values: 16 exact-match entries and a 12-bit hash, so 128 table words and a 7-bit write index. With these sizes every entry and its priority against higher indices can be written, an out-of-range entry index (16 and above) is reachable, and all four shift modes land on hash words across the whole table, including the top word. Random addresses are drawn so that broadcast, group, individual and entry-copy addresses all occur under randomly changing enables.

// File: rtl/rx_dest_screen_pkg.sv
package rx_dest_screen_pkg;

    localparam int ADDR_W = 48;
    localparam int REG_W  = 32;

    typedef enum logic [1:0] {
        SEL_CTRL   = 2'd0,
        SEL_ENT_LO = 2'd1,
        SEL_ENT_HI = 2'd2,
        SEL_HASH   = 2'd3
    } cfg_sel_e;

    typedef struct packed {
        logic [1:0] hash_mode;
        logic       ucast_pro;
        logic       mcast_pro;
        logic       bcast_en;
    } ctrl_t;

    typedef enum logic [2:0] {
        WHY_NONE,
        WHY_BCAST,
        WHY_MCAST,
        WHY_UCAST,
        WHY_EXACT,
        WHY_HASH
    } why_e;

    function automatic logic [2:0] hash_shift(input logic [1:0] mode);
        case (mode)
            2'd0:    return 3'd4;
            2'd1:    return 3'd3;
            2'd2:    return 3'd2;
            default: return 3'd0;
        endcase
    endfunction

    function automatic logic is_bcast(input logic [ADDR_W-1:0] a);
        return &a;
    endfunction

    function automatic logic is_group(input logic [ADDR_W-1:0] a);
        return a[0];
    endfunction

endpackage

// File: rtl/rx_dest_screen_ctrl.sv
module rx_dest_screen_ctrl
    import rx_dest_screen_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             we_i,
    input  logic [1:0]       sel_i,
    input  logic [REG_W-1:0] wdata_i,
    output ctrl_t            ctrl_o
);

    ctrl_t ctrl_q;
    logic  wr_ctrl;
    logic  unused_bits;

    assign wr_ctrl     = we_i && (cfg_sel_e'(sel_i) == SEL_CTRL);
    assign unused_bits = ^{wdata_i[REG_W-1:6], wdata_i[3]};

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= '0;
        end else if (wr_ctrl) begin
            ctrl_q.bcast_en  <= wdata_i[0];
            ctrl_q.mcast_pro <= wdata_i[1];
            ctrl_q.ucast_pro <= wdata_i[2];
            ctrl_q.hash_mode <= wdata_i[5:4];
        end
    end

    assign ctrl_o = ctrl_q;

    // R10
    ctrl_write_lands_chk: assert property (@(posedge clk) disable iff (rst)
        wr_ctrl |=> (ctrl_q.hash_mode == $past(wdata_i[5:4])) &&
                    (ctrl_q.bcast_en == $past(wdata_i[0])));

    // R10
    ctrl_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !wr_ctrl |=> $stable(ctrl_q));

endmodule

// File: rtl/rx_dest_screen_cam.sv
module rx_dest_screen_cam
    import rx_dest_screen_pkg::*;
#(
    parameter int NUM_ENTRIES = 16,
    parameter int IDX_W       = 7,
    localparam int ENT_IW     = $clog2(NUM_ENTRIES)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              we_i,
    input  logic [1:0]        sel_i,
    input  logic [IDX_W-1:0]  idx_i,
    input  logic [REG_W-1:0]  wdata_i,
    input  logic [ADDR_W-1:0] addr_i,
    output logic              hit_o,
    output logic [ENT_IW-1:0] hit_idx_o
);

    logic [REG_W-1:0]       ent_lo  [NUM_ENTRIES];
    logic [15:0]            ent_hi  [NUM_ENTRIES];
    logic [NUM_ENTRIES-1:0] ent_vld;
    logic [NUM_ENTRIES-1:0] hit_vec;
    logic                   in_range;
    logic [ENT_IW-1:0]      eidx;
    logic                   wr_lo;
    logic                   wr_hi;
    logic                   unused_bits;

    assign in_range    = int'(idx_i) < NUM_ENTRIES;
    assign eidx        = idx_i[ENT_IW-1:0];
    assign wr_lo       = we_i && in_range && (cfg_sel_e'(sel_i) == SEL_ENT_LO);
    assign wr_hi       = we_i && in_range && (cfg_sel_e'(sel_i) == SEL_ENT_HI);
    assign unused_bits = ^wdata_i[REG_W-2:16];

    always_ff @(posedge clk) begin
        if (rst) begin
            ent_vld <= '0;
            for (int i = 0; i < NUM_ENTRIES; i++) begin
                ent_lo[i] <= '0;
                ent_hi[i] <= '0;
            end
        end else begin
            if (wr_lo) begin
                ent_lo[eidx] <= wdata_i;
            end
            if (wr_hi) begin
                ent_hi[eidx]  <= wdata_i[15:0];
                ent_vld[eidx] <= wdata_i[REG_W-1];
            end
        end
    end

    // parallel compare, one comparator per entry
    for (genvar g = 0; g < NUM_ENTRIES; g++) begin : g_cmp
        assign hit_vec[g] = ent_vld[g] && ({ent_hi[g], ent_lo[g]} == addr_i);
    end

    // lowest index wins
    always_comb begin
        hit_o     = 1'b0;
        hit_idx_o = '0;
        for (int i = NUM_ENTRIES - 1; i >= 0; i--) begin
            if (hit_vec[i]) begin
                hit_o     = 1'b1;
                hit_idx_o = ENT_IW'(i);
            end
        end
    end

    // R7
    ent_valid_write_chk: assert property (@(posedge clk) disable iff (rst)
        wr_hi |=> ent_vld[$past(eidx)] == $past(wdata_i[REG_W-1]));

    // R7
    ent_no_stray_write_chk: assert property (@(posedge clk) disable iff (rst)
        !(wr_lo || wr_hi) |=> $stable(ent_vld));

endmodule

// File: rtl/rx_dest_screen_hash.sv
module rx_dest_screen_hash
    import rx_dest_screen_pkg::*;
#(
    parameter int HASH_W       = 12,
    parameter int IDX_W        = 7,
    localparam int BIT_SEL_W   = $clog2(REG_W),
    localparam int WORD_SEL_W  = HASH_W - BIT_SEL_W,
    localparam int WORDS       = 1 << WORD_SEL_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             we_i,
    input  logic [1:0]       sel_i,
    input  logic [IDX_W-1:0] idx_i,
    input  logic [REG_W-1:0] wdata_i,
    input  logic [1:0]       mode_i,
    input  logic [15:0]      key_i,
    output logic             bit_o
);

    logic [REG_W-1:0]      tbl_q [WORDS];
    logic                  wr_word;
    logic [WORD_SEL_W-1:0] widx;
    logic [15:0]           shifted;
    logic [HASH_W-1:0]     hash;
    logic [REG_W-1:0]      word_sel;

    assign wr_word = we_i && (cfg_sel_e'(sel_i) == SEL_HASH) && (int'(idx_i) < WORDS);
    assign widx    = idx_i[WORD_SEL_W-1:0];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < WORDS; i++) begin
                tbl_q[i] <= '0;
            end
        end else if (wr_word) begin
            tbl_q[widx] <= wdata_i;
        end
    end

    assign shifted  = key_i >> hash_shift(mode_i);
    assign hash     = shifted[HASH_W-1:0];
    assign word_sel = tbl_q[hash[HASH_W-1:BIT_SEL_W]];
    assign bit_o    = word_sel[hash[BIT_SEL_W-1:0]];

    // R10
    hash_word_write_chk: assert property (@(posedge clk) disable iff (rst)
        wr_word |=> tbl_q[$past(widx)] == $past(wdata_i));

endmodule

// File: rtl/rx_dest_screen.sv
module rx_dest_screen
    import rx_dest_screen_pkg::*;
#(
    parameter int NUM_ENTRIES = 16,
    parameter int HASH_W      = 12,
    localparam int ENT_IW     = $clog2(NUM_ENTRIES),
    localparam int WIDX_W     = HASH_W - $clog2(REG_W),
    localparam int IDX_W      = (ENT_IW > WIDX_W) ? ENT_IW : WIDX_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              addr_valid_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              cfg_we_i,
    input  logic [1:0]        cfg_sel_i,
    input  logic [IDX_W-1:0]  cfg_idx_i,
    input  logic [REG_W-1:0]  cfg_wdata_i,
    output logic              verdict_valid_o,
    output logic              accept_o,
    output logic              match_hit_o,
    output logic [ENT_IW-1:0] match_idx_o
);

    ctrl_t             ctrl;
    logic              cam_hit;
    logic [ENT_IW-1:0] cam_idx;
    logic              hash_bit;
    logic              a_bcast;
    logic              a_group;
    why_e              why;

    rx_dest_screen_ctrl u_ctrl (
        .clk     (clk),
        .rst     (rst),
        .we_i    (cfg_we_i),
        .sel_i   (cfg_sel_i),
        .wdata_i (cfg_wdata_i),
        .ctrl_o  (ctrl)
    );

    rx_dest_screen_cam #(
        .NUM_ENTRIES (NUM_ENTRIES),
        .IDX_W       (IDX_W)
    ) u_cam (
        .clk       (clk),
        .rst       (rst),
        .we_i      (cfg_we_i),
        .sel_i     (cfg_sel_i),
        .idx_i     (cfg_idx_i),
        .wdata_i   (cfg_wdata_i),
        .addr_i    (addr_i),
        .hit_o     (cam_hit),
        .hit_idx_o (cam_idx)
    );

    rx_dest_screen_hash #(
        .HASH_W (HASH_W),
        .IDX_W  (IDX_W)
    ) u_hash (
        .clk     (clk),
        .rst     (rst),
        .we_i    (cfg_we_i),
        .sel_i   (cfg_sel_i),
        .idx_i   (cfg_idx_i),
        .wdata_i (cfg_wdata_i),
        .mode_i  (ctrl.hash_mode),
        .key_i   (addr_i[ADDR_W-1:ADDR_W-16]),
        .bit_o   (hash_bit)
    );

    assign a_bcast = is_bcast(addr_i);
    assign a_group = is_group(addr_i);

    // ordered decision: enables, then bank, then hash
    always_comb begin
        if (a_bcast && ctrl.bcast_en) begin
            why = WHY_BCAST;
        end else if (a_group && !a_bcast && ctrl.mcast_pro) begin
            why = WHY_MCAST;
        end else if (!a_group && ctrl.ucast_pro) begin
            why = WHY_UCAST;
        end else if (cam_hit) begin
            why = WHY_EXACT;
        end else if (hash_bit) begin
            why = WHY_HASH;
        end else begin
            why = WHY_NONE;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            verdict_valid_o <= 1'b0;
            accept_o        <= 1'b0;
            match_hit_o     <= 1'b0;
            match_idx_o     <= '0;
        end else begin
            verdict_valid_o <= addr_valid_i;
            accept_o        <= addr_valid_i && (why != WHY_NONE);
            match_hit_o     <= addr_valid_i && (why == WHY_EXACT);
            match_idx_o     <= (addr_valid_i && why == WHY_EXACT) ? cam_idx : '0;
        end
    end

    // R1
    verdict_follows_strobe_chk: assert property (@(posedge clk) disable iff (rst)
        addr_valid_i |=> verdict_valid_o);

    // R1
    verdict_only_after_strobe_chk: assert property (@(posedge clk) disable iff (rst)
        !addr_valid_i |=> !verdict_valid_o && !accept_o && !match_hit_o);

    // R6
    hit_implies_accept_chk: assert property (@(posedge clk) disable iff (rst)
        match_hit_o |-> accept_o && verdict_valid_o);

    // R3
    bcast_accept_chk: assert property (@(posedge clk) disable iff (rst)
        (addr_valid_i && (&addr_i) && ctrl.bcast_en) |=> accept_o && !match_hit_o);

    // R5
    ucast_accept_chk: assert property (@(posedge clk) disable iff (rst)
        (addr_valid_i && !addr_i[0] && ctrl.ucast_pro) |=> accept_o && !match_hit_o);

endmodule

// File: tb/rx_dest_screen_bench.sv
module rx_dest_screen_bench;

    localparam int N_ENT  = 16;
    localparam int N_WORD = 128;

    logic        clk = 1'b0;
    logic        rst;
    logic        addr_valid_i;
    logic [47:0] addr_i;
    logic        cfg_we_i;
    logic [1:0]  cfg_sel_i;
    logic [6:0]  cfg_idx_i;
    logic [31:0] cfg_wdata_i;
    logic        verdict_valid_o;
    logic        accept_o;
    logic        match_hit_o;
    logic [3:0]  match_idx_o;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    // bench model of the writable state
    logic [31:0] m_ctrl;
    logic [31:0] m_lo  [N_ENT];
    logic [31:0] m_hi  [N_ENT];
    logic [31:0] m_hash[N_WORD];

    rx_dest_screen u_rx_dest_screen (
        .clk             (clk),
        .rst             (rst),
        .addr_valid_i    (addr_valid_i),
        .addr_i          (addr_i),
        .cfg_we_i        (cfg_we_i),
        .cfg_sel_i       (cfg_sel_i),
        .cfg_idx_i       (cfg_idx_i),
        .cfg_wdata_i     (cfg_wdata_i),
        .verdict_valid_o (verdict_valid_o),
        .accept_o        (accept_o),
        .match_hit_o     (match_hit_o),
        .match_idx_o     (match_idx_o)
    );

    always #5 clk = ~clk;

    task automatic model_reset();
        m_ctrl = '0;
        for (int i = 0; i < N_ENT; i++) begin
            m_lo[i] = '0;
            m_hi[i] = '0;
        end
        for (int i = 0; i < N_WORD; i++) m_hash[i] = '0;
    endtask

    function automatic void model_write(input logic [1:0] sel, input logic [6:0] idx,
                                        input logic [31:0] d);
        case (sel)
            2'd0: m_ctrl = d;
            2'd1: if (idx < N_ENT) m_lo[idx[3:0]] = d;
            2'd2: if (idx < N_ENT) m_hi[idx[3:0]] = d;
            default: m_hash[idx] = d;
        endcase
    endfunction

    // expected verdict; tag names the deciding requirement
    function automatic void model_verdict(input logic [47:0] a, output logic acc,
                                          output logic hit, output logic [3:0] idx,
                                          output string tag);
        logic       bc = &a;
        logic       grp = a[0];
        logic [15:0] key;
        logic [11:0] h;
        int          sh;
        acc = 0; hit = 0; idx = 0; tag = "R8";
        if (bc && m_ctrl[0]) begin acc = 1; tag = "R3"; return; end
        if (grp && !bc && m_ctrl[1]) begin acc = 1; tag = "R4"; return; end
        if (!grp && m_ctrl[2]) begin acc = 1; tag = "R5"; return; end
        for (int i = N_ENT - 1; i >= 0; i--) begin
            if (m_hi[i][31] && {m_hi[i][15:0], m_lo[i]} == a) begin
                acc = 1; hit = 1; idx = 4'(i); tag = "R6";
            end
        end
        if (hit) return;
        case (m_ctrl[5:4])
            2'd0: sh = 4;
            2'd1: sh = 3;
            2'd2: sh = 2;
            default: sh = 0;
        endcase
        key = a[47:32];
        h   = 12'((key >> sh) & 16'h0fff);
        acc = m_hash[h[11:5]][h[4:0]];
    endfunction

    task automatic compare(input string tag, input logic ev, input logic ea,
                           input logic eh, input logic [3:0] ei);
        checks++;
        if ({verdict_valid_o, accept_o, match_hit_o, match_idx_o} !== {ev, ea, eh, ei}) begin
            fails++;
            $display("FAIL %s actual v=%0b acc=%0b hit=%0b idx=%0d expected v=%0b acc=%0b hit=%0b idx=%0d",
                     tag, verdict_valid_o, accept_o, match_hit_o, match_idx_o, ev, ea, eh, ei);
        end
    endtask

    // called just after a falling edge; returns just after the next one
    task automatic cfg_write(input logic [1:0] sel, input logic [6:0] idx, input logic [31:0] d);
        cfg_we_i = 1; cfg_sel_i = sel; cfg_idx_i = idx; cfg_wdata_i = d;
        @(negedge clk);
        cfg_we_i = 0;
        model_write(sel, idx, d);
    endtask

    task automatic strobe(input logic [47:0] a, input string extra);
        logic ea, eh; logic [3:0] ei; string tag;
        model_verdict(a, ea, eh, ei, tag);
        addr_valid_i = 1; addr_i = a;
        @(negedge clk);
        addr_valid_i = 0;
        compare({"R1 ", tag, extra}, 1'b1, ea, eh, ei);
    endtask

    // R9: write and strobe at the same edge, verdict from old state
    task automatic strobe_with_write(input logic [47:0] a, input logic [1:0] sel,
                                     input logic [6:0] idx, input logic [31:0] d);
        logic ea, eh; logic [3:0] ei; string tag;
        model_verdict(a, ea, eh, ei, tag);
        addr_valid_i = 1; addr_i = a;
        cfg_we_i = 1; cfg_sel_i = sel; cfg_idx_i = idx; cfg_wdata_i = d;
        @(negedge clk);
        addr_valid_i = 0; cfg_we_i = 0;
        model_write(sel, idx, d);
        compare({"R9 ", tag}, 1'b1, ea, eh, ei);
    endtask

    task automatic idle_check();
        @(negedge clk);
        compare("R1 idle", 1'b0, 1'b0, 1'b0, 4'd0);
    endtask

    function automatic logic [47:0] rand_addr();
        return {$urandom(), $urandom()} & 48'hffff_ffff_ffff;
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL R1 watchdog actual=hung expected=finished");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        logic [47:0] a;
        logic [11:0] h;
        void'($urandom(32'd2024));
        rst = 1; addr_valid_i = 0; addr_i = '0;
        cfg_we_i = 0; cfg_sel_i = 0; cfg_idx_i = 0; cfg_wdata_i = 0;
        model_reset();
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        compare("R2 reset", 1'b0, 1'b0, 1'b0, 4'd0);

        // R2: everything rejected after reset
        strobe(48'hffff_ffff_ffff, " R2");
        strobe(48'h0000_1234_5601, " R2");
        strobe(48'h0000_1234_5600, " R2");
        idle_check();

        // R3 broadcast accept
        cfg_write(2'd0, 7'd0, 32'h1);
        strobe(48'hffff_ffff_ffff, " R3");
        // R4 group promiscuous does not take broadcast
        cfg_write(2'd0, 7'd0, 32'h2);
        strobe(48'hffff_ffff_ffff, " R4 bcast");
        strobe(48'h0a0b_0c0d_0e01, " R4");
        strobe(48'h0a0b_0c0d_0e00, " R4 unicast");
        // R5
        cfg_write(2'd0, 7'd0, 32'h4);
        strobe(48'h0a0b_0c0d_0e00, " R5");
        strobe(48'h0a0b_0c0d_0e01, " R5 group");

        // R6 priority and broadcast through the bank; R10 selects
        cfg_write(2'd0, 7'd0, 32'h0);
        cfg_write(2'd1, 7'd3, 32'h4433_2211);
        cfg_write(2'd2, 7'd3, 32'h8abc_6655);
        cfg_write(2'd1, 7'd9, 32'h4433_2211);
        cfg_write(2'd2, 7'd9, 32'h8000_6655);
        strobe(48'h6655_4433_2211, " R6 lowest");
        cfg_write(2'd1, 7'd12, 32'hffff_ffff);
        cfg_write(2'd2, 7'd12, 32'h8000_ffff);
        strobe(48'hffff_ffff_ffff, " R6 bcast");
        // R7 invalid entry and out-of-range index
        cfg_write(2'd1, 7'd5, 32'h1357_9bdf);
        cfg_write(2'd2, 7'd5, 32'h0000_2468);
        strobe(48'h2468_1357_9bdf, " R7 invalid");
        cfg_write(2'd1, 7'd4, 32'h0f0f_0f0e);
        cfg_write(2'd2, 7'd20, 32'h8000_7777);
        strobe(48'h0000_0f0f_0f0e, " R7 range");
        strobe(48'h7777_0f0f_0f0e, " R7 range");

        // R8 every mode, set the selected bit then probe
        for (int m = 0; m < 4; m++) begin
            a = {16'(16'hb7c6 + m * 16'h1111), 32'h1020_3040};
            cfg_write(2'd0, 7'd0, 32'(m) << 4);
            strobe(a, " R8 before");
            case (m)
                0: h = 12'((a[47:32] >> 4) & 16'hfff);
                1: h = 12'((a[47:32] >> 3) & 16'hfff);
                2: h = 12'((a[47:32] >> 2) & 16'hfff);
                default: h = 12'(a[47:32] & 16'hfff);
            endcase
            cfg_write(2'd3, {2'b0, h[11:5]}, m_hash[h[11:5]] | (32'h1 << h[4:0]));
            strobe(a, " R8 set");
        end
        cfg_write(2'd3, 7'd127, 32'h8000_0000);
        cfg_write(2'd0, 7'd0, 32'h30);
        strobe(48'h0fff_0000_0000, " R8 top word");

        // R9
        cfg_write(2'd0, 7'd0, 32'h0);
        strobe_with_write(48'h0000_5555_0000, 2'd0, 7'd0, 32'h4);
        strobe(48'h0000_5555_0000, " R9 after");
        idle_check();

        // random mix
        for (int it = 0; it < 600; it++) begin
            int r = int'($urandom_range(0, 9));
            if (r == 0) begin
                logic [31:0] c = $urandom() & 32'h37;
                if ($urandom_range(0, 2) != 0) c[2:0] = 3'b0;
                cfg_write(2'd0, 7'd0, c);
            end else if (r == 1) begin
                cfg_write(2'd3, 7'($urandom_range(0, 127)), $urandom());
            end else if (r == 2) begin
                logic [6:0] ei = 7'($urandom_range(0, 19));
                cfg_write(2'd1, ei, $urandom());
                cfg_write(2'd2, ei, $urandom());
            end else begin
                int k = int'($urandom_range(0, 3));
                if (k == 0) a = 48'hffff_ffff_ffff;
                else if (k == 1) begin
                    int e = int'($urandom_range(0, N_ENT - 1));
                    a = {m_hi[e][15:0], m_lo[e]};
                end else a = rand_addr();
                strobe(a, " random");
                if ($urandom_range(0, 7) == 0) idle_check();
            end
        end

        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule